// File: doc/BRIEF.md
# Ethernet Traffic Statistics Counter Bank

This block keeps 32-bit traffic counters for one Ethernet MAC. Each direction has its own set of counters. The transmit and receive datapaths each report a finished frame with a one-cycle strobe. The strobe carries the frame length in octets, a flag that says whether the frame was good, and an address class. From these, the bank updates frame and octet totals in two forms (all frames, and good frames only), good broadcast and good multicast frame counts, and a six-bin length histogram.

Software reaches the bank through a plain register port. Reads are combinational in the cycle that the read strobe is high, and writes take effect at the clock edge. A control register sets the counting modes:
- clear all counters;
- saturate instead of wrapping;
- clear a counter when software reads it;
- freeze all counters;
- load every counter near its half or full rollover point.

Each counter owns a status bit in its direction's status register. The status bit is set when the counter crosses half range or reaches full range. A mask register per direction gates these status bits onto a single interrupt output.

Top module: `mac_stats_bank`

## Requirements
- R1: After reset, every counter, both status registers, both mask registers and the control register read as zero, and `stat_irq` is low.
- R2: The register map is as follows.
  - Control is at 0x100.
  - Receive status is at 0x104 and transmit status at 0x108.
  - Receive mask is at 0x10C and transmit mask at 0x110.
  - Transmit counter i is at 0x114+4i and receive counter i is at 0x180+4i.
  - Counter index i runs 0..11: 0 all-frame octets, 1 all-frame count, 2 good broadcast, 3 good multicast, 4..9 histogram bins, 10 good octets, 11 good frames.
  - Status and mask bit i belong to counter i.
- R3: Every frame strobe, good or bad, adds its length to counter 0 and one to counter 1 of its direction.
- R4: A good frame adds its length to counter 10 and one to counter 11. It adds one to counter 2 when its class is 2 (broadcast) and to counter 3 when its class is 1 (multicast). Class 0 is unicast. Bad frames change none of these four counters.
- R5: Every frame, good or bad, adds one to exactly one histogram bin, chosen by its length:
  - bin 4 for at most 64 octets;
  - bin 5 for 65..127;
  - bin 6 for 128..255;
  - bin 7 for 256..511;
  - bin 8 for 512..1023;
  - bin 9 for 1024 or more.
- R6: Writing control with bit 0 set clears every counter at the following clock edge. Bit 0 reads back 1 for that one cycle and then reads back 0. Events in that cycle are dropped.
- R7: With control bit 1 set, an increment that would pass all ones leaves the counter at 0xFFFFFFFF, and the counter stays there.
- R8: With control bit 2 set, reading a counter returns its value and restarts it at zero. If an increment lands in the same cycle, the counter restarts at the increment amount instead.
- R9: With control bit 3 set, counters ignore frame strobes and reads do not clear them. Clear and preset still act.
- R10: Writing control with bit 4 set loads every counter, one cycle later, with 0xFFFFFFF0 if bit 5 is 1 or 0x7FFFFFF0 if bit 5 is 0. Bit 4 clears itself after one cycle, and a preset raises no status bit.
- R11: An increment that moves a counter's bit 31 from 0 to 1, or that makes it reach 0xFFFFFFFF from another value, sets that counter's status bit. Reading a status register clears it, but a setting event in the same cycle wins.
- R12: `stat_irq` is high exactly when some status bit is set while its mask bit is 0. Writing all ones to a mask register masks every source in that direction.
- R13: With control bit 1 clear, a counter wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_frame_stb | input | 1 | Transmit frame completed |
| tx_frame_len | input | 16 | Transmit frame length in octets |
| tx_frame_ok | input | 1 | Transmit frame was good |
| tx_frame_cls | input | 2 | Transmit class: 0 unicast, 1 multicast, 2 broadcast |
| rx_frame_stb | input | 1 | Receive frame completed |
| rx_frame_len | input | 16 | Receive frame length in octets |
| rx_frame_ok | input | 1 | Receive frame was good |
| rx_frame_cls | input | 2 | Receive class: 0 unicast, 1 multicast, 2 broadcast |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while the read strobe is high |
| stat_irq | output | 1 | Interrupt, the OR of unmasked status bits |

## Verification
From the ports, the hardest conditions to reach are a counter crossing bit 31, reaching all ones, or wrapping, because that would take billions of frames. The stimulus uses both preset levels to start every counter sixteen counts or octets below a boundary. It then sends a few frames, and it does this with saturation both off and on. A second case that is hard to reach is a clear-on-read read that lands in the same cycle as a frame strobe for the same counter. The bench drives such a read together with a strobe, then adds a long pseudo-random phase that mixes strobes, reads, mode changes and mask writes. A behavioural model checks every read and the interrupt on every clock.

// File: rtl/mac_stats_pkg.sv
// Shared constants for the statistics counter bank: counter indices,
// register addresses and the length-to-bin mapping.
// Assumes a 12-bit byte address space and a fixed set of 12 counters per
// direction.
package mac_stats_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int NUM_CNT  = 12;
    localparam int NUM_BIN  = 6;
    localparam int NUM_DIR  = 2;   // 0 transmit, 1 receive

    // counter indices inside one direction
    localparam int IX_OCT_ALL  = 0;
    localparam int IX_FRM_ALL  = 1;
    localparam int IX_BCAST    = 2;
    localparam int IX_MCAST    = 3;
    localparam int IX_BIN0     = 4;
    localparam int IX_OCT_GOOD = 10;
    localparam int IX_FRM_GOOD = 11;

    // address classes carried by a frame strobe
    localparam logic [1:0] CLS_MCAST = 2'd1;
    localparam logic [1:0] CLS_BCAST = 2'd2;

    // control register bit positions
    localparam int CB_CLEAR  = 0;
    localparam int CB_SAT    = 1;
    localparam int CB_RDCLR  = 2;
    localparam int CB_FREEZE = 3;
    localparam int CB_PRESET = 4;
    localparam int CB_FULL   = 5;
    localparam int CTRL_W    = 6;

    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h100;
    localparam logic [ADDR_W-1:0] A_RX_STS  = 12'h104;
    localparam logic [ADDR_W-1:0] A_TX_STS  = 12'h108;
    localparam logic [ADDR_W-1:0] A_RX_MASK = 12'h10C;
    localparam logic [ADDR_W-1:0] A_TX_MASK = 12'h110;
    localparam logic [ADDR_W-1:0] A_TX_CNT  = 12'h114;
    localparam logic [ADDR_W-1:0] A_RX_CNT  = 12'h180;

    // byte address of counter k in direction d
    function automatic logic [ADDR_W-1:0] cnt_addr(input int d, input int k);
        logic [ADDR_W-1:0] base;
        base = (d == 0) ? A_TX_CNT : A_RX_CNT;
        return base + ADDR_W'(4 * k);
    endfunction

    // histogram bin for a frame length: <=64, then power-of-two bands up to 1024+
    function automatic int len_bin(input logic [15:0] len);
        int b;
        b = 0;
        if (len > 16'd64) begin
            b = NUM_BIN - 1;
            for (int j = NUM_BIN - 2; j >= 1; j--)
                if (32'(len) < (32'd64 << j)) b = j;
        end
        return b;
    endfunction

endpackage

// File: rtl/mac_stats_decode.sv
// Turns one direction's frame strobe into per-counter increment enables
// and amounts.
// Assumes the strobe is a single-cycle pulse. A class of 3 counts as
// unicast.
module mac_stats_decode
    import mac_stats_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                            stb_i,
    input  logic [LEN_W-1:0]                len_i,
    input  logic                            ok_i,
    input  logic [1:0]                      cls_i,
    output logic [NUM_CNT-1:0]              inc_en_o,
    output logic [NUM_CNT-1:0][LEN_W-1:0]   inc_amt_o
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    // selects which counters a frame touches and by how much
    always_comb begin
        int bin;
        bin = len_bin(16'(len_i));
        inc_en_o  = '0;
        for (int k = 0; k < NUM_CNT; k++) inc_amt_o[k] = ONE;
        inc_amt_o[IX_OCT_ALL]  = len_i;
        inc_amt_o[IX_OCT_GOOD] = len_i;
        inc_en_o[IX_OCT_ALL]   = stb_i;
        inc_en_o[IX_FRM_ALL]   = stb_i;
        inc_en_o[IX_OCT_GOOD]  = stb_i && ok_i;
        inc_en_o[IX_FRM_GOOD]  = stb_i && ok_i;
        inc_en_o[IX_BCAST]     = stb_i && ok_i && (cls_i == CLS_BCAST);
        inc_en_o[IX_MCAST]     = stb_i && ok_i && (cls_i == CLS_MCAST);
        for (int b = 0; b < NUM_BIN; b++)
            inc_en_o[IX_BIN0 + b] = stb_i && (bin == b);
    end

endmodule

// File: rtl/mac_stats_cell.sv
// One statistics counter with clear, preset, saturation, freeze and
// clear-on-read. It flags half-range and full-range events.
// Assumes clear has priority over preset, and preset over counting.
module mac_stats_cell #(
    parameter int CNT_W = 32,
    parameter int AMT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             preset_i,
    input  logic             full_i,
    input  logic             sat_i,
    input  logic             frz_i,
    input  logic             rd_clr_i,
    input  logic             inc_en_i,
    input  logic [AMT_W-1:0] inc_amt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);

    localparam logic [CNT_W-1:0] ONES     = '1;
    localparam logic [CNT_W-1:0] GAP      = CNT_W'(15);
    localparam logic [CNT_W-1:0] PRE_FULL = ONES - GAP;
    localparam logic [CNT_W-1:0] PRE_HALF = (ONES >> 1) - GAP;

    logic [CNT_W-1:0] cnt_q, base, upd, nxt;
    logic [CNT_W:0]   sum_w;
    logic             apply;

    // next value: clear, preset, then read-clear and increment
    always_comb begin
        base  = (rd_clr_i && !frz_i) ? '0 : cnt_q;
        apply = inc_en_i && !frz_i;
        sum_w = {1'b0, base} + (CNT_W+1)'(inc_amt_i);
        upd   = (sat_i && sum_w[CNT_W]) ? ONES : sum_w[CNT_W-1:0];
        if (clr_i)         nxt = '0;
        else if (preset_i) nxt = full_i ? PRE_FULL : PRE_HALF;
        else if (apply)    nxt = upd;
        else               nxt = base;
        flag_o = !clr_i && !preset_i && apply &&
                 ((!base[CNT_W-1] && upd[CNT_W-1]) || (upd == ONES && base != ONES));
    end

    // counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= nxt;
    end

    assign cnt_o = cnt_q;

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0);
    // R9
    frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_i && !clr_i && !preset_i) |=> $stable(cnt_q));
    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i && cnt_q == ONES && !clr_i && !preset_i && !rd_clr_i) |=> cnt_q == ONES);
    // R10
    preset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_i && !clr_i) |=> (cnt_q == PRE_FULL || cnt_q == PRE_HALF));
    // R8
    rdclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !frz_i && !inc_en_i && !clr_i && !preset_i) |=> cnt_q == '0);

endmodule

// File: rtl/mac_stats_bank.sv
// Statistics counter bank for one MAC: two directions of 12 counters, the
// control, status and mask registers, the read mux and the interrupt.
// Assumes a read returns data combinationally in the cycle its strobe is
// high. Register side effects act at the clock edge that ends that cycle.
module mac_stats_bank
    import mac_stats_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_frame_stb,
    input  logic [LEN_W-1:0]  tx_frame_len,
    input  logic              tx_frame_ok,
    input  logic [1:0]        tx_frame_cls,
    input  logic              rx_frame_stb,
    input  logic [LEN_W-1:0]  rx_frame_len,
    input  logic              rx_frame_ok,
    input  logic [1:0]        rx_frame_cls,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              stat_irq
);

    localparam logic [CTRL_W-1:0] PULSE_BITS = CTRL_W'((1 << CB_CLEAR) | (1 << CB_PRESET));

    logic [CTRL_W-1:0]          ctrl_q;
    logic                       ctrl_wr;
    logic [NUM_DIR-1:0]         stb;
    logic [NUM_DIR-1:0][LEN_W-1:0] len;
    logic [NUM_DIR-1:0]         ok;
    logic [NUM_DIR-1:0][1:0]    cls;
    logic [NUM_DIR-1:0][NUM_CNT-1:0]            inc_en, flag, hit;
    logic [NUM_DIR-1:0][NUM_CNT-1:0][LEN_W-1:0] inc_amt;
    logic [NUM_DIR-1:0][NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic [NUM_DIR-1:0][NUM_CNT-1:0]            sts_q;
    logic [NUM_DIR-1:0][DATA_W-1:0]             mask_q;
    logic [NUM_DIR-1:0]         sts_rd, mask_wr;
    logic [NUM_DIR-1:0][ADDR_W-1:0] sts_addr, mask_addr;

    assign stb = {rx_frame_stb, tx_frame_stb};
    assign len = {rx_frame_len, tx_frame_len};
    assign ok  = {rx_frame_ok,  tx_frame_ok};
    assign cls = {rx_frame_cls, tx_frame_cls};
    assign sts_addr  = {A_RX_STS,  A_TX_STS};
    assign mask_addr = {A_RX_MASK, A_TX_MASK};
    assign ctrl_wr   = reg_wr_en && (reg_addr == A_CTRL);

    // address decode of counter, status and mask registers
    always_comb begin
        for (int d = 0; d < NUM_DIR; d++) begin
            sts_rd[d]  = reg_rd_en && (reg_addr == sts_addr[d]);
            mask_wr[d] = reg_wr_en && (reg_addr == mask_addr[d]);
            for (int k = 0; k < NUM_CNT; k++)
                hit[d][k] = (reg_addr == cnt_addr(d, k));
        end
    end

    // control register; clear and preset bits drop after one cycle
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= reg_wdata[CTRL_W-1:0];
        else              ctrl_q <= ctrl_q & ~PULSE_BITS;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        mac_stats_decode #(.LEN_W(LEN_W)) u_dec (
            .stb_i     (stb[d]),
            .len_i     (len[d]),
            .ok_i      (ok[d]),
            .cls_i     (cls[d]),
            .inc_en_o  (inc_en[d]),
            .inc_amt_o (inc_amt[d])
        );
        for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
            mac_stats_cell #(.CNT_W(CNT_W), .AMT_W(LEN_W)) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr_i     (ctrl_q[CB_CLEAR]),
                .preset_i  (ctrl_q[CB_PRESET]),
                .full_i    (ctrl_q[CB_FULL]),
                .sat_i     (ctrl_q[CB_SAT]),
                .frz_i     (ctrl_q[CB_FREEZE]),
                .rd_clr_i  (reg_rd_en && hit[d][k] && ctrl_q[CB_RDCLR]),
                .inc_en_i  (inc_en[d][k]),
                .inc_amt_i (inc_amt[d][k]),
                .cnt_o     (cnt[d][k]),
                .flag_o    (flag[d][k])
            );
        end

        // R11
        sts_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_rd[d] && flag[d] == '0) |=> sts_q[d] == '0);
        // R11
        sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[d] != '0) |=> (sts_q[d] & $past(flag[d])) == $past(flag[d]));
    end

    // status (set by counter events, cleared by read) and mask registers
    always_ff @(posedge clk) begin
        for (int d = 0; d < NUM_DIR; d++) begin
            if (!rst_n) begin
                sts_q[d]  <= '0;
                mask_q[d] <= '0;
            end else begin
                sts_q[d] <= (sts_rd[d] ? '0 : sts_q[d]) | flag[d];
                if (mask_wr[d]) mask_q[d] <= reg_wdata;
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) reg_rdata = DATA_W'(ctrl_q);
        for (int d = 0; d < NUM_DIR; d++) begin
            if (reg_addr == sts_addr[d])  reg_rdata = DATA_W'(sts_q[d]);
            if (reg_addr == mask_addr[d]) reg_rdata = mask_q[d];
            for (int k = 0; k < NUM_CNT; k++)
                if (hit[d][k]) reg_rdata = DATA_W'(cnt[d][k]);
        end
    end

    // interrupt: any status bit whose mask bit is clear
    always_comb begin
        stat_irq = 1'b0;
        for (int d = 0; d < NUM_DIR; d++)
            stat_irq = stat_irq | (|(sts_q[d] & ~mask_q[d][NUM_CNT-1:0]));
    end

    // R6
    ctrl_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_CLEAR] && !ctrl_wr) |=> !ctrl_q[CB_CLEAR]);
    // R10
    preset_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_PRESET] && !ctrl_wr) |=> !ctrl_q[CB_PRESET]);

endmodule

// File: tb/test_mac_stats_bank.sv
module test_mac_stats_bank;
    import mac_stats_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_frame_stb = 0, tx_frame_ok = 0, rx_frame_stb = 0, rx_frame_ok = 0;
    logic [15:0] tx_frame_len = 0, rx_frame_len = 0;
    logic [1:0]  tx_frame_cls = 0, rx_frame_cls = 0;
    logic reg_wr_en = 0, reg_rd_en = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic stat_irq;

    int checks = 0, failures = 0;
    string tag = "R1";
    bit done = 0;

    // model state
    longint unsigned m_cnt [2][NUM_CNT];
    int unsigned m_sts [2];
    longint unsigned m_mask [2];
    int unsigned m_ctrl;
    localparam longint unsigned ONES = 64'hFFFF_FFFF;

    always #10 clk = ~clk;   // 50 MHz

    mac_stats_bank i_mac_stats_bank (
        .clk(clk), .rst_n(rst_n),
        .tx_frame_stb(tx_frame_stb), .tx_frame_len(tx_frame_len),
        .tx_frame_ok(tx_frame_ok), .tx_frame_cls(tx_frame_cls),
        .rx_frame_stb(rx_frame_stb), .rx_frame_len(rx_frame_len),
        .rx_frame_ok(rx_frame_ok), .rx_frame_cls(rx_frame_cls),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_irq(stat_irq)
    );

    function automatic int mbin(input int l);
        if (l <= 64) return 0;
        if (l < 128) return 1;
        if (l < 256) return 2;
        if (l < 512) return 3;
        if (l < 1024) return 4;
        return 5;
    endfunction

    // increment enable and amount for counter k from a frame
    function automatic void mcount(input int k, input bit ev, input int l, input bit g,
                                   input int c, output bit en, output longint unsigned amt);
        amt = 1;
        en = 0;
        if (k == 0) begin en = ev; amt = l; end
        else if (k == 1) en = ev;
        else if (k == 2) en = ev && g && c == 2;
        else if (k == 3) en = ev && g && c == 1;
        else if (k >= 4 && k <= 9) en = ev && mbin(l) == k - 4;
        else if (k == 10) begin en = ev && g; amt = l; end
        else en = ev && g;
    endfunction

    function automatic longint unsigned exp_read(input logic [11:0] a);
        if (a == 12'h100) return m_ctrl;
        if (a == 12'h104) return m_sts[1];
        if (a == 12'h108) return m_sts[0];
        if (a == 12'h10C) return m_mask[1];
        if (a == 12'h110) return m_mask[0];
        for (int d = 0; d < 2; d++)
            for (int k = 0; k < NUM_CNT; k++)
                if (a == 12'((d ? 12'h180 : 12'h114) + 4 * k)) return m_cnt[d][k];
        return 0;
    endfunction

    // behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                for (int k = 0; k < NUM_CNT; k++) m_cnt[d][k] = 0;
                m_sts[d] = 0; m_mask[d] = 0;
            end
            m_ctrl = 0;
        end else begin
            for (int d = 0; d < 2; d++) begin
                bit ev, g; int l, c;
                ev = d ? rx_frame_stb : tx_frame_stb;
                g  = d ? rx_frame_ok : tx_frame_ok;
                l  = d ? int'(rx_frame_len) : int'(tx_frame_len);
                c  = d ? int'(rx_frame_cls) : int'(tx_frame_cls);
                if (reg_rd_en && reg_addr == (d ? 12'h104 : 12'h108)) m_sts[d] = 0;
                for (int k = 0; k < NUM_CNT; k++) begin
                    bit en, frz; longint unsigned amt, base, s;
                    mcount(k, ev, l, g, c, en, amt);
                    frz = m_ctrl[3];
                    base = m_cnt[d][k];
                    if (reg_rd_en && m_ctrl[2] && !frz &&
                        reg_addr == 12'((d ? 12'h180 : 12'h114) + 4 * k)) base = 0;
                    if (m_ctrl[0]) m_cnt[d][k] = 0;
                    else if (m_ctrl[4]) m_cnt[d][k] = m_ctrl[5] ? 64'hFFFF_FFF0 : 64'h7FFF_FFF0;
                    else if (en && !frz) begin
                        s = base + amt;
                        if (s > ONES) s = m_ctrl[1] ? ONES : (s & ONES);
                        if ((base < 64'h8000_0000 && s >= 64'h8000_0000) ||
                            (s == ONES && base != ONES)) m_sts[d] |= (1 << k);
                        m_cnt[d][k] = s;
                    end else m_cnt[d][k] = base;
                end
                if (reg_wr_en && reg_addr == (d ? 12'h10C : 12'h110)) m_mask[d] = reg_wdata;
            end
            if (reg_wr_en && reg_addr == 12'h100) m_ctrl = reg_wdata & 32'h3F;
            else m_ctrl = m_ctrl & ~32'h11;
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ei;
            ei = ((m_sts[0] & ~m_mask[0][11:0]) | (m_sts[1] & ~m_mask[1][11:0])) != 0;
            checks++;
            if (stat_irq !== ei) begin
                failures++;
                $display("FAIL R12 irq actual=%0b expected=%0b t=%0t", stat_irq, ei, $time);
            end
            if (reg_rd_en) begin
                longint unsigned e;
                e = exp_read(reg_addr);
                checks++;
                if (64'(reg_rdata) !== e) begin
                    failures++;
                    $display("FAIL %s addr=%h actual=%h expected=%h t=%0t",
                             tag, reg_addr, reg_rdata, e, $time);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
        tx_frame_stb = 0; rx_frame_stb = 0; reg_wr_en = 0; reg_rd_en = 0;
    endtask

    task automatic tx(input int l, input bit g, input int c);
        tick(); tx_frame_stb = 1; tx_frame_len = 16'(l); tx_frame_ok = g; tx_frame_cls = 2'(c);
    endtask

    task automatic rx(input int l, input bit g, input int c);
        tick(); rx_frame_stb = 1; rx_frame_len = 16'(l); rx_frame_ok = g; rx_frame_cls = 2'(c);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        tick(); reg_wr_en = 1; reg_addr = a; reg_wdata = v;
    endtask

    task automatic rd(input logic [11:0] a, input string t);
        tick(); reg_rd_en = 1; reg_addr = a; tag = t;
    endtask

    task automatic dump(input string t);
        rd(12'h100, t); rd(12'h104, t); rd(12'h108, t); rd(12'h10C, t); rd(12'h110, t);
        for (int d = 0; d < 2; d++)
            for (int k = 0; k < NUM_CNT; k++) rd(cnt_addr(d, k), t);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        dump("R1");
        // R3 R4 R5: mixed lengths, classes and good/bad, both directions
        tx(64, 1, 0); tx(65, 0, 1); tx(127, 1, 1); tx(128, 1, 2); tx(300, 1, 0);
        tx(600, 0, 2); tx(1023, 1, 1); tx(1024, 1, 2); tx(1518, 0, 2); tx(40, 1, 0);
        rx(255, 1, 2); rx(256, 0, 1); rx(511, 1, 1); rx(512, 1, 0); rx(9000, 1, 2);
        tick(); tx_frame_stb = 1; tx_frame_len = 70; tx_frame_ok = 1; tx_frame_cls = 1;
        rx_frame_stb = 1; rx_frame_len = 2000; rx_frame_ok = 0; rx_frame_cls = 2;
        dump("R3");
        rd(cnt_addr(0, 2), "R4"); rd(cnt_addr(0, 3), "R4"); rd(cnt_addr(1, 10), "R4");
        for (int b = 0; b < 6; b++) rd(cnt_addr(1, 4 + b), "R5");
        dump("R2");
        // R10 R13: full preset without saturation, then wrap
        wr(12'h100, 32'h30); rd(12'h100, "R10"); rd(12'h100, "R10");
        rd(cnt_addr(0, 0), "R10");
        tx(100, 1, 0); rd(cnt_addr(0, 0), "R13"); rd(cnt_addr(0, 10), "R13");
        // R11: frame counter reaches all ones after 14 more frames
        for (int i = 0; i < 14; i++) tx(64, 0, 0);
        rd(12'h108, "R11"); rd(12'h108, "R11"); rd(cnt_addr(0, 1), "R11");
        // R7: saturation with full preset
        wr(12'h100, 32'h32); tick(); tx(1500, 1, 2); tx(1500, 1, 2);
        rd(cnt_addr(0, 0), "R7"); rd(cnt_addr(0, 10), "R7"); rd(cnt_addr(0, 2), "R7");
        rd(12'h108, "R11");
        // R10 R11 R12: half preset, crossing bit 31, masking
        wr(12'h100, 32'h10); tick(); rd(cnt_addr(1, 0), "R10");
        rx(20, 1, 0); tick(); tick();
        wr(12'h10C, 32'hFFFF_FFFF); tick(); rd(12'h10C, "R12");
        wr(12'h10C, 32'h0); tick(); rd(12'h104, "R11"); tick();
        // R6: global clear
        wr(12'h100, 32'h01); tx(64, 1, 0); rd(12'h100, "R6"); dump("R6");
        // R9: freeze ignores frames and read-clear
        wr(12'h100, 32'h0C); tx(200, 1, 2); rx(300, 1, 1); rd(cnt_addr(0, 0), "R9");
        dump("R9");
        // R8: clear on read, with and without a simultaneous frame
        wr(12'h100, 32'h04); tx(100, 1, 0); tx(50, 1, 0);
        rd(cnt_addr(0, 0), "R8"); rd(cnt_addr(0, 0), "R8");
        tx(80, 1, 0); rd(cnt_addr(0, 0), "R8");
        tick(); tx_frame_stb = 1; tx_frame_len = 33; tx_frame_ok = 1; tx_frame_cls = 0;
        reg_rd_en = 1; reg_addr = cnt_addr(0, 0); tag = "R8";
        rd(cnt_addr(0, 0), "R8");
        // R3 R7 R8 R11 R13: pseudo-random mix
        lf = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            tick();
            tx_frame_stb = lf[0]; tx_frame_len = 16'(lf[11:1]) + 16'd1;
            tx_frame_ok = lf[12]; tx_frame_cls = lf[14:13];
            rx_frame_stb = lf[15]; rx_frame_len = 16'(lf[26:16]) + 16'd1;
            rx_frame_ok = lf[27]; rx_frame_cls = lf[29:28];
            if (lf[31:30] == 2'b11) begin
                reg_rd_en = 1; tag = "R3";
                reg_addr = lf[20] ? cnt_addr(lf[21], int'(lf[25:22]) % 12)
                                  : 12'h100 + 12'(4 * (int'(lf[23:21]) % 5));
            end else if (lf[31:26] == 6'b100000) begin
                reg_wr_en = 1; reg_addr = 12'h100;
                reg_wdata = {26'd0, lf[5], lf[4] & lf[9], 1'b0, lf[2], lf[3], lf[7] & lf[8] & lf[6]};
            end else if (lf[31:26] == 6'b100001) begin
                reg_wr_en = 1; reg_addr = lf[3] ? 12'h10C : 12'h110;
                reg_wdata = {20'd0, lf[19:8]};
            end
        end
        dump("R13");
        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule